// File: doc/BRIEF.md
# Programmable Skew Clock Output Bank

This block is a cycle-level digital model of one bank of clock outputs. A fast tick clock, where one tick is one time unit, steps a phase counter. The counter defines a square reference wave whose period is 32, 16 or 8 ticks, chosen by a ternary range input. Four output pairs each produce a registered copy of that wave. Each copy can lead or lag the reference by a chosen number of time units, or it can be a divided or inverted copy. Each pair has its own two-digit ternary select code.

A bank-level stop input parks every pair except pair 2 at a defined level. Pair 2 stays free-running so that it can serve as a feedback clock. An edge-select input chooses whether outputs align to the rising or the falling reference edge. A power input that is low forces the bank low. Starting and stopping happen only at the tick where an output already sits at its parking level, so no shortened pulse ever appears. When the range, the edge select or any select code changes, the phase restarts and every pair is held at its parking level for one full period.

The phase generator is a two-state machine. In HOLD the phase counts but outputs are parked. HOLD moves to RUN when the period completes. Any state moves to HOLD on reset or on a configuration change. Each pair is also a two-state machine. PARKED moves to RUNNING at a parking-level tick while it is enabled. RUNNING moves to PARKED at a parking-level tick while it is stopped. Hold and power-down force PARKED at once.

Top module: `skew_clock_bank`

## Requirements
- R1: While the synchronous reset `rst_n` is low, all eight outputs are 0. After release, the phase counter starts at 0 in HOLD.
- R2: The reference period P is 32 ticks for range code 2'b00, 16 ticks for 2'b01 and 8 ticks for 2'b10. Range code 2'b11 (undriven) reads as 2'b01.
- R3: A select port holds the high digit in bits [3:2] and the low digit in bits [1:0]. Each digit is LOW=2'b00, MID=2'b01 or HIGH=2'b10, and 2'b11 reads as MID. The code index is 3*high+low, running 0 (LL) to 8 (HH).
- R4: Pairs 1 and 2 apply a skew s = index-4 time units, where positive means a lag. With edge select high, the ideal output at phase ph is 1 when ((ph-s) mod P) < P/2. Each output shows the value for phase ph one tick later.
- R5: For pair 3, index 0 gives divide-by-2 and index 8 gives divide-by-4. Indices 1 to 7 give skew s = 2*(index-4).
- R6: Pair 4 follows pair 3, except that index 8 gives the complement of the zero-skew output.
- R7: Divided outputs change at the phase wrap. Periods are counted from the restart. Divide-by-2 is 1 in even periods, and divide-by-4 is 1 in periods 0 and 1 mod 4, so their rising edges coincide.
- R8: While `stop_req` is high, pairs 1, 3 and 4 park, and pair 2 is unaffected.
- R9: The parking level is 0 when `edge_pos` is 1 and 1 when it is 0. The inverted mode of pair 4 parks at the opposite level.
- R10: A pair parks or resumes only at a tick where its ideal value equals its parking level. Every pulse it produces is therefore a whole one.
- R11: With `edge_pos` low, skewed outputs are the complement of the rising-edge form, so they align to the falling reference edge.
- R12: With `pwr_on` low, all outputs are 0 one tick later. After `pwr_on` returns high, each pair resumes only at a parking-level tick.
- R13: A change in range, edge select or any select code restarts the phase at 0. All pairs are then held at their parking level for P ticks before the outputs run again.
- R14: The two outputs of a pair, q[2n-2] and q[2n-1] for pair n, are equal on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-unit tick clock |
| rst_n | input | 1 | Synchronous reset, active low |
| range_sel | input | 2 | Ternary period range select |
| edge_pos | input | 1 | 1: align to rising reference edge, 0: align to falling edge |
| stop_req | input | 1 | Synchronous stop for all pairs except pair 2 |
| pwr_on | input | 1 | 0 forces all outputs low |
| sel_p1 | input | 4 | Two-digit ternary select, pair 1 |
| sel_p2 | input | 4 | Two-digit ternary select, pair 2 |
| sel_p3 | input | 4 | Two-digit ternary select, pair 3 |
| sel_p4 | input | 4 | Two-digit ternary select, pair 4 |
| q | output | 8 | Clock outputs, two per pair, pair n on bits 2n-1 and 2n-2 |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that any skew magnitude stays below the period, which the tap tables guarantee for all three ranges. The phase-range check also relies on a range change always being seen as a configuration change in the same cycle. The stimulus changes inputs only on the falling half of the tick clock. It walks every select code on every pair, every range and both edge polarities, and it asserts stop and power-down only after a configuration has settled.

// File: rtl/skb_pkg.sv
package skb_pkg;

    typedef enum logic [1:0] {MD_SKEW, MD_DIV2, MD_DIV4, MD_INV} tap_mode_t;
    typedef enum logic {PH_HOLD, PH_RUN} gen_state_t;
    typedef enum logic {PS_PARKED, PS_RUNNING} pair_state_t;

    // Ternary digit: 2'b11 (undriven) reads as MID.
    function automatic logic [1:0] tern_level(input logic [1:0] raw);
        return (raw == 2'b11) ? 2'd1 : raw;
    endfunction

    function automatic logic [3:0] code_index(input logic [3:0] sel);
        return 4'(3 * tern_level(sel[3:2])) + 4'(tern_level(sel[1:0]));
    endfunction

endpackage

// File: rtl/skb_phase_gen.sv
module skb_phase_gen
    import skb_pkg::*;
#(
    parameter int PH_W  = 5,
    parameter int CFG_W = 19,
    localparam int PER_W = PH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       range_sel,
    input  logic [CFG_W-1:0] cfg,
    output logic [PH_W-1:0]  ph,
    output logic [PER_W-1:0] period,
    output logic [1:0]       cyc,
    output logic             active
);

    localparam int FULL = 1 << PH_W;

    gen_state_t       state, state_n;
    logic [PH_W-1:0]  ph_n;
    logic [1:0]       cyc_n;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg, last;

    always_comb begin
        unique case (tern_level(range_sel))
            2'd0:    period = PER_W'(FULL);
            2'd1:    period = PER_W'(FULL >> 1);
            default: period = PER_W'(FULL >> 2);
        endcase
    end

    assign cfg_chg = (cfg != cfg_q);
    assign last    = ({1'b0, ph} == period - 1'b1);

    always_comb begin
        state_n = state;
        ph_n    = ph;
        cyc_n   = cyc;
        if (cfg_chg) begin
            state_n = PH_HOLD;
            ph_n    = '0;
            cyc_n   = '0;
        end else begin
            unique case (state)
                PH_HOLD: begin
                    if (last) begin
                        state_n = PH_RUN;
                        ph_n    = '0;
                        cyc_n   = '0;
                    end else begin
                        ph_n = ph + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (last) begin
                        ph_n  = '0;
                        cyc_n = cyc + 1'b1;
                    end else begin
                        ph_n = ph + 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_HOLD;
            ph    <= '0;
            cyc   <= '0;
            cfg_q <= cfg;
        end else begin
            state <= state_n;
            ph    <= ph_n;
            cyc   <= cyc_n;
            cfg_q <= cfg;
        end
    end

    // outputs
    always_comb begin
        active = (state == PH_RUN) && !cfg_chg;
    end

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> ({1'b0, ph} < period));

    assert_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (state == PH_HOLD && ph == '0));

endmodule

// File: rtl/skb_tap_decode.sv
module skb_tap_decode
    import skb_pkg::*;
#(
    parameter bit FINE     = 1'b1,
    parameter bit LAST_INV = 1'b0
) (
    input  logic [3:0] sel,
    output tap_mode_t  mode,
    output logic [3:0] skew
);

    logic [3:0] idx;
    logic [4:0] sdiff;

    assign idx   = code_index(sel);
    assign sdiff = {1'b0, idx} - 5'd4;

    generate
        if (FINE) begin : g_fine
            always_comb begin
                mode = MD_SKEW;
                skew = sdiff[3:0];
            end
        end else begin : g_coarse
            always_comb begin
                mode = MD_SKEW;
                skew = {sdiff[2:0], 1'b0};
                if (idx == 4'd0) begin
                    mode = MD_DIV2;
                    skew = '0;
                end else if (idx == 4'd8) begin
                    mode = LAST_INV ? MD_INV : MD_DIV4;
                    skew = '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/skb_pair_out.sv
module skb_pair_out
    import skb_pkg::*;
#(
    parameter int PH_W    = 5,
    parameter bit KEEP_ON = 1'b0,
    localparam int PER_W  = PH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             pd_n,
    input  logic             stop_req,
    input  logic             edge_pos,
    input  tap_mode_t        mode,
    input  logic [3:0]       skew,
    input  logic [PH_W-1:0]  ph,
    input  logic [PER_W-1:0] period,
    input  logic [1:0]       cyc,
    output logic             q
);

    pair_state_t      st, st_n;
    logic [3:0]       mag4;
    logic [PER_W-1:0] mag, dm, pos, rel;
    logic             base, zb, nv, stop_lvl, stop_eff, q_n;

    assign stop_eff = KEEP_ON ? 1'b0 : stop_req;

    always_comb begin
        mag4 = skew[3] ? (4'd0 - skew) : skew;
        mag  = PER_W'(mag4);
        dm   = skew[3] ? (period - mag) : mag;
        pos  = PER_W'(ph) + period - dm;
        rel  = (pos >= period) ? (pos - period) : pos;
        base = (rel < (period >> 1));
        zb   = ({1'b0, ph} < (period >> 1));
        unique case (mode)
            MD_SKEW: nv = edge_pos ? base : ~base;
            MD_DIV2: nv = ~cyc[0];
            MD_DIV4: nv = ~cyc[1];
            MD_INV:  nv = edge_pos ? ~zb : zb;
        endcase
        stop_lvl = (mode == MD_INV) ? edge_pos : ~edge_pos;
    end

    always_comb begin
        st_n = st;
        if (!pd_n || !active) begin
            st_n = PS_PARKED;
        end else if (nv == stop_lvl) begin
            unique case (st)
                PS_PARKED:  if (!stop_eff) st_n = PS_RUNNING;
                PS_RUNNING: if (stop_eff)  st_n = PS_PARKED;
            endcase
        end
    end

    always_comb begin
        if (!pd_n)                    q_n = 1'b0;
        else if (st_n == PS_RUNNING)  q_n = nv;
        else                          q_n = stop_lvl;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PS_PARKED;
        else        st <= st_n;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_n;
    end

    assert_pd_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (q == 1'b0));

    assert_hold_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !active) |=> (q == $past(stop_lvl)));

    assert_parked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && st == PS_PARKED && stop_eff) |=> (q == $past(stop_lvl)));

    assert_no_runt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && active && st == PS_PARKED && nv != stop_lvl) |=> (q == $past(stop_lvl)));

endmodule

// File: rtl/skew_clock_bank.sv
module skew_clock_bank
    import skb_pkg::*;
#(
    parameter int PH_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] range_sel,
    input  logic       edge_pos,
    input  logic       stop_req,
    input  logic       pwr_on,
    input  logic [3:0] sel_p1,
    input  logic [3:0] sel_p2,
    input  logic [3:0] sel_p3,
    input  logic [3:0] sel_p4,
    output logic [7:0] q
);

    localparam int NPAIR = 4;
    localparam int PER_W = PH_W + 1;
    localparam int CFG_W = 3 + 4 * NPAIR;

    logic [PH_W-1:0]  ph;
    logic [PER_W-1:0] period;
    logic [1:0]       cyc;
    logic             active;
    logic [3:0]       sel_arr [NPAIR];
    logic [NPAIR-1:0] pq;

    assign sel_arr[0] = sel_p1;
    assign sel_arr[1] = sel_p2;
    assign sel_arr[2] = sel_p3;
    assign sel_arr[3] = sel_p4;

    skb_phase_gen #(.PH_W(PH_W), .CFG_W(CFG_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_sel (range_sel),
        .cfg       ({range_sel, edge_pos, sel_p1, sel_p2, sel_p3, sel_p4}),
        .ph        (ph),
        .period    (period),
        .cyc       (cyc),
        .active    (active)
    );

    generate
        for (genvar i = 0; i < NPAIR; i++) begin : g_pair
            tap_mode_t  mode;
            logic [3:0] skew;

            skb_tap_decode #(.FINE(i < 2), .LAST_INV(i == 3)) u_dec (
                .sel  (sel_arr[i]),
                .mode (mode),
                .skew (skew)
            );

            skb_pair_out #(.PH_W(PH_W), .KEEP_ON(i == 1)) u_out (
                .clk      (clk),
                .rst_n    (rst_n),
                .active   (active),
                .pd_n     (pwr_on),
                .stop_req (stop_req),
                .edge_pos (edge_pos),
                .mode     (mode),
                .skew     (skew),
                .ph       (ph),
                .period   (period),
                .cyc      (cyc),
                .q        (pq[i])
            );

            assign q[2*i]   = pq[i];
            assign q[2*i+1] = pq[i];
        end
    endgenerate

endmodule

// File: tb/sim_skew_clock_bank.sv
module sim_skew_clock_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] range_sel = 2'b00;
    logic       edge_pos = 1'b1;
    logic       stop_req = 1'b0;
    logic       pwr_on = 1'b1;
    logic [3:0] sel_p1 = 4'b0101, sel_p2 = 4'b0101, sel_p3 = 4'b0101, sel_p4 = 4'b0101;
    logic [7:0] q;

    int checks = 0;
    int errors = 0;

    // reference model state
    int          m_ph = 0, m_cyc = 0;
    bit          m_run = 0;
    bit  [3:0]   m_live = '0;
    bit  [3:0]   m_q = '0;
    logic [18:0] m_cfg = '0;

    always #4 clk = ~clk;

    skew_clock_bank u0 (
        .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .edge_pos(edge_pos),
        .stop_req(stop_req), .pwr_on(pwr_on), .sel_p1(sel_p1), .sel_p2(sel_p2),
        .sel_p3(sel_p3), .sel_p4(sel_p4), .q(q)
    );

    function automatic int digit(input logic [1:0] raw);
        return (raw == 2'b11) ? 1 : int'(raw);
    endfunction

    function automatic int period_of(input logic [1:0] r);
        int d = digit(r);
        return 32 >> d;
    endfunction

    function automatic int idx_of(input logic [3:0] s);
        return 3 * digit(s[3:2]) + digit(s[1:0]);
    endfunction

    function automatic logic [3:0] code_sel(input int c, input bit fl);
        logic [1:0] hi = 2'(c / 3);
        logic [1:0] lo = 2'(c % 3);
        if (fl && hi == 2'd1) hi = 2'b11;
        if (fl && lo == 2'd1) lo = 2'b11;
        return {hi, lo};
    endfunction

    function automatic logic [3:0] sel_of(input int p);
        case (p)
            0: return sel_p1;
            1: return sel_p2;
            2: return sel_p3;
            default: return sel_p4;
        endcase
    endfunction

    function automatic string tag_of(input int p, input int idx);
        if (p < 2) return "R4";
        if (idx == 0 || (idx == 8 && p == 2)) return "R7";
        if (idx == 8) return "R6";
        return "R5";
    endfunction

    task automatic pair_eval(input int p, input int idx, input bit pe,
                             output bit nv, output bit sl);
        int per = period_of(range_sel);
        int sk = 0;
        int kind = 0;
        int rel;
        bit b;
        if (p < 2) sk = idx - 4;
        else if (idx == 0) kind = 1;
        else if (idx == 8) kind = (p == 2) ? 2 : 3;
        else sk = 2 * (idx - 4);
        sl = !pe;
        case (kind)
            0: begin
                rel = (((m_ph - sk) % per) + per) % per;
                b = (rel < per / 2);
                nv = pe ? b : !b;
            end
            1: nv = ((m_cyc % 2) == 0);
            2: nv = (((m_cyc / 2) % 2) == 0);
            default: begin
                b = (m_ph < per / 2);
                nv = pe ? !b : b;
                sl = pe;
            end
        endcase
    endtask

    task automatic model_step();
        logic [18:0] cv = {range_sel, edge_pos, sel_p1, sel_p2, sel_p3, sel_p4};
        int per = period_of(range_sel);
        bit chg, act, nv, sl;
        if (!rst_n) begin
            m_ph = 0; m_cyc = 0; m_run = 0; m_live = '0; m_q = '0; m_cfg = cv;
            return;
        end
        chg = (cv != m_cfg);
        act = m_run && !chg;
        for (int p = 0; p < 4; p++) begin
            pair_eval(p, idx_of(sel_of(p)), edge_pos, nv, sl);
            if (!pwr_on) begin
                m_live[p] = 0; m_q[p] = 0;
            end else if (!act) begin
                m_live[p] = 0; m_q[p] = sl;
            end else begin
                if (nv == sl) m_live[p] = (p == 1) ? 1'b1 : !stop_req;
                m_q[p] = m_live[p] ? nv : sl;
            end
        end
        if (chg) begin
            m_run = 0; m_ph = 0; m_cyc = 0;
        end else if (m_ph == per - 1) begin
            if (!m_run) m_cyc = 0; else m_cyc = (m_cyc + 1) % 4;
            m_run = 1; m_ph = 0;
        end else begin
            m_ph = m_ph + 1;
        end
        m_cfg = cv;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(posedge clk);
            @(negedge clk);
            for (int p = 0; p < 4; p++) begin
                check({tag, " ", tag_of(p, idx_of(sel_of(p)))}, q[2*p], m_q[p]);
                check("R14", q[2*p+1], q[2*p]);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        run_ticks(4, "R1");
        rst_n = 1'b1;
        run_ticks(40, "R1 R13");

        for (int e = 1; e >= 0; e--) begin
            for (int r = 0; r < 3; r++) begin
                for (int c = 0; c < 9; c++) begin
                    int per = 32 >> r;
                    bit fl = (r == 2);
                    edge_pos  = e[0];
                    range_sel = 2'(r);
                    sel_p1 = code_sel(c, fl);
                    sel_p2 = code_sel((c + 4) % 9, fl);
                    sel_p3 = code_sel(c, fl);
                    sel_p4 = code_sel((c + 5) % 9, fl);
                    run_ticks(3 * per + 1, "R2 R3 R11 R13");
                    stop_req = 1'b1;
                    run_ticks(per + per / 2, "R8 R9 R10");
                    stop_req = 1'b0;
                    run_ticks(2 * per, "R10 R11");
                end
            end
        end

        // undriven range code reads as MID
        edge_pos = 1'b1;
        range_sel = 2'b11;
        sel_p1 = 4'b1111; sel_p2 = 4'b0010; sel_p3 = 4'b0000; sel_p4 = 4'b1010;
        run_ticks(80, "R2 R3");

        // power-down and recovery
        range_sel = 2'b01;
        run_ticks(40, "R13");
        pwr_on = 1'b0;
        run_ticks(12, "R12");
        pwr_on = 1'b1;
        run_ticks(48, "R12 R10");

        // stop on inverted pair 4 with falling-edge alignment
        edge_pos = 1'b0;
        range_sel = 2'b10;
        run_ticks(24, "R13 R6");
        stop_req = 1'b1;
        run_ticks(20, "R9 R8");
        stop_req = 1'b0;
        run_ticks(20, "R9 R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule